// File: doc/BRIEF.md
# Serial Channel Command and Status Unit

This block is the host-facing half of one channel of an asynchronous serial controller. It sits between a byte-wide host register bus and a byte-level line stream. It does not shift bits, generate baud rates or decode mode settings. Its job is to track whether the receiver and transmitter are switched on and whether the holding registers are ready or empty. It also signals receive and transmit events to the interrupt logic.

The host uses four offsets. Offset 1 takes mode writes. Offset 3 returns status on a read and takes clock-select writes. Offset 5 takes command writes. Offset 7 returns the received byte on a read and loads the transmit byte on a write. Mode and clock-select writes are accepted and have no effect.

Both line-side interfaces are valid/ready streams.
- **Receive stream:** the line side offers a byte with `rx_valid`. The block accepts it on a clock where `rx_ready` is also high. `rx_ready` is high only while the receiver is enabled and the one-deep holding register is empty. A byte offered while the holding register is full is therefore held off, not lost.
- **Transmit stream:** a byte loaded by the host appears on `tx_data` with `tx_valid`. Both stay unchanged until a clock where `tx_ready` is high.

Top module: `sio_chan_ctrl`

## Requirements
- R1: After reset the receiver and transmitter are disabled. All flags, `rx_ready`, `tx_valid`, `rx_int`, `tx_int`, `rx_evt` and `tx_evt` are low, and a status read returns 0x00.
- R2: A command write (offset 5) acts on the receiver through bits [1:0]. Value 01 enables the receiver and value 10 disables it. Values 00 and 11 leave it unchanged. A disabled receiver never accepts a byte.
- R3: A command write acts on the transmitter through bits [3:2]; values 00 and 11 leave it unchanged.
  - Value 10 disables the transmitter and clears transmit-ready and transmit-empty in the next cycle.
  - Value 01 enables it. It sets both flags in the next cycle only if no byte is waiting on the transmit stream.
- R4: `rx_ready` equals (receiver enabled and holding register empty). A byte is taken on a clock where `rx_valid` and `rx_ready` are both high. In the following cycle receive-ready is set and `rx_evt` is high for exactly one cycle.
- R5: A read of offset 7 returns the held byte on `host_rdata`. From the next cycle receive-ready and `rx_int` are clear.
- R6: A write to offset 7 while transmit-ready is set has these effects from the next cycle:
  - `tx_valid` is high with the written byte on `tx_data`;
  - transmit-ready, transmit-empty and `tx_int` are clear.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` stays unchanged.
- R8: One cycle after the stream accepts a byte, transmit-ready and transmit-empty are set again if the transmitter is enabled, and `tx_evt` is high for one cycle. If the transmitter is disabled they stay clear. `tx_evt` is high for exactly the cycles in which transmit-ready has just risen.
- R9: A read of offset 3 returns the status byte:
  - bit 0 receive ready, bit 1 receive full (equal to bit 0, since the holding register is one byte deep);
  - bit 2 transmit ready, bit 3 transmit empty;
  - bits 7..4 (error bits) zero.
  - `rx_int` mirrors bit 0 and `tx_int` mirrors bit 2.
  - `host_rdata` is 0x00 when no read of offset 3 or 7 is in progress.
- R10: Writes to offsets 1 and 3 change no flag and no output. A write to offset 7 while transmit-ready is clear is ignored and leaves the waiting byte unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | ADDR_W | Register offset |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe (side effects on the clock edge) |
| host_wdata | input | DATA_W | Write data |
| host_rdata | output | DATA_W | Read data, valid during a read |
| rx_valid | input | 1 | Line side offers a received byte |
| rx_data | input | DATA_W | Received byte |
| rx_ready | output | 1 | Block can take a received byte |
| tx_valid | output | 1 | Byte waiting for the line side |
| tx_data | output | DATA_W | Outgoing byte |
| tx_ready | input | 1 | Line side takes the outgoing byte |
| rx_int | output | 1 | Receive interrupt source (receive ready) |
| tx_int | output | 1 | Transmit interrupt source (transmit ready) |
| rx_evt | output | 1 | One-cycle pulse: byte received |
| tx_evt | output | 1 | One-cycle pulse: transmit-ready rose |

## Verification
Directed sequences cover the corner cases:
- command values 00 and 11 against 01 and 10, which separates "no change" decoding from an inverted or ignored field;
- a second received byte offered while the first is still held, which separates hold-off from overwrite;
- a transmit load while the line side stalls, which separates stable holding of the byte from a changing one;
- transmitter disable and re-enable while a byte is still waiting, which shows whether the flags wrongly return before the byte is drained.

A long stretch of random host operations, random line-side offers and random transmit back-pressure is then compared cycle by cycle against a behavioural model. This catches interactions between commands, reads and stream handshakes that the directed cases do not reach.

// File: rtl/sio_pkg.sv
package sio_pkg;
  // Register offsets inside one channel (a neighbour decodes the channel bit above these)
  localparam int unsigned OFS_MODE = 1;
  localparam int unsigned OFS_STAT = 3;  // read: status, write: clock select
  localparam int unsigned OFS_CMD  = 5;
  localparam int unsigned OFS_DATA = 7;  // read: receive byte, write: transmit byte

  // Status bit positions
  localparam int unsigned ST_RX_RDY   = 0;
  localparam int unsigned ST_RX_FULL  = 1;
  localparam int unsigned ST_TX_RDY   = 2;
  localparam int unsigned ST_TX_EMPTY = 3;

  // Two-bit command field codes
  typedef enum logic [1:0] {
    FLD_HOLD = 2'b00,
    FLD_ON   = 2'b01,
    FLD_OFF  = 2'b10,
    FLD_NOP  = 2'b11
  } fld_t;
endpackage

// File: rtl/sio_host_dec.sv
module sio_host_dec
  import sio_pkg::*;
#(
  parameter int unsigned ADDR_W = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [3:0]        cmd_bits,
  output logic              rx_on,
  output logic              rx_off,
  output logic              tx_on,
  output logic              tx_off,
  output logic              load,
  output logic              take,
  output logic              stat_sel,
  output logic              data_sel
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);

  logic cmd_wr;
  fld_t rx_fld, tx_fld;

  always_comb begin
    cmd_wr   = wr && (addr == A_CMD);
    rx_fld   = fld_t'(cmd_bits[1:0]);
    tx_fld   = fld_t'(cmd_bits[3:2]);
    rx_on    = cmd_wr && (rx_fld == FLD_ON);
    rx_off   = cmd_wr && (rx_fld == FLD_OFF);
    tx_on    = cmd_wr && (tx_fld == FLD_ON);
    tx_off   = cmd_wr && (tx_fld == FLD_OFF);
    load     = wr && (addr == A_DATA);
    take     = rd && (addr == A_DATA);
    stat_sel = rd && (addr == A_STAT);
    data_sel = take;
  end
endmodule

// File: rtl/sio_rx_hold.sv
module sio_rx_hold #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_on,
  input  logic              rx_off,
  input  logic              take,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  output logic [DATA_W-1:0] hold,
  output logic              full,
  output logic              evt
);
  logic en_q;
  logic cap;

  assign in_ready = en_q & ~full;
  assign cap      = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      full <= 1'b0;
      hold <= '0;
      evt  <= 1'b0;
    end else begin
      if (rx_on)       en_q <= 1'b1;
      else if (rx_off) en_q <= 1'b0;
      if (cap) begin
        full <= 1'b1;
        hold <= in_data;
      end else if (take) begin
        full <= 1'b0;
      end
      evt <= cap;
    end
  end
endmodule

// File: rtl/sio_tx_path.sv
module sio_tx_path #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_on,
  input  logic              tx_off,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  input  logic              out_ready,
  output logic              rdy,
  output logic              emt,
  output logic              evt
);
  logic en_q, pend_q, done_q;
  logic en_d, rdy_d, emt_d;
  logic accept, drain;

  assign accept    = load & rdy;
  assign drain     = pend_q & out_ready;
  assign out_valid = pend_q;

  always_comb begin
    en_d  = en_q;
    rdy_d = rdy;
    emt_d = emt;
    if (tx_off) begin
      en_d  = 1'b0;
      rdy_d = 1'b0;
      emt_d = 1'b0;
    end else if (tx_on) begin
      en_d = 1'b1;
      if (!pend_q) begin
        rdy_d = 1'b1;
        emt_d = 1'b1;
      end
    end else if (accept) begin
      rdy_d = 1'b0;
      emt_d = 1'b0;
    end else if (done_q && en_q) begin
      rdy_d = 1'b1;
      emt_d = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= 1'b0;
      rdy      <= 1'b0;
      emt      <= 1'b0;
      evt      <= 1'b0;
      pend_q   <= 1'b0;
      done_q   <= 1'b0;
      out_data <= '0;
    end else begin
      en_q   <= en_d;
      rdy    <= rdy_d;
      emt    <= emt_d;
      evt    <= rdy_d & ~rdy;
      done_q <= drain;
      if (accept) begin
        pend_q   <= 1'b1;
        out_data <= load_data;
      end else if (drain) begin
        pend_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/sio_chan_ctrl.sv
module sio_chan_ctrl
  import sio_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_wr,
  input  logic              host_rd,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              rx_valid,
  input  logic [DATA_W-1:0] rx_data,
  output logic              rx_ready,
  output logic              tx_valid,
  output logic [DATA_W-1:0] tx_data,
  input  logic              tx_ready,
  output logic              rx_int,
  output logic              tx_int,
  output logic              rx_evt,
  output logic              tx_evt
);
  logic rx_on, rx_off, tx_on, tx_off, load, take, stat_sel, data_sel;
  logic rx_full, tx_rdy, tx_emt;
  logic [DATA_W-1:0] rx_hold;
  logic [DATA_W-1:0] status;

  sio_host_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr(host_addr), .wr(host_wr), .rd(host_rd), .cmd_bits(host_wdata[3:0]),
    .rx_on(rx_on), .rx_off(rx_off), .tx_on(tx_on), .tx_off(tx_off),
    .load(load), .take(take), .stat_sel(stat_sel), .data_sel(data_sel)
  );

  sio_rx_hold #(.DATA_W(DATA_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_on(rx_on), .rx_off(rx_off), .take(take),
    .in_valid(rx_valid), .in_data(rx_data), .in_ready(rx_ready),
    .hold(rx_hold), .full(rx_full), .evt(rx_evt)
  );

  sio_tx_path #(.DATA_W(DATA_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_on(tx_on), .tx_off(tx_off),
    .load(load), .load_data(host_wdata),
    .out_valid(tx_valid), .out_data(tx_data), .out_ready(tx_ready),
    .rdy(tx_rdy), .emt(tx_emt), .evt(tx_evt)
  );

  assign rx_int = rx_full;
  assign tx_int = tx_rdy;

  always_comb begin
    status              = '0;
    status[ST_RX_RDY]   = rx_full;
    status[ST_RX_FULL]  = rx_full;
    status[ST_TX_RDY]   = tx_rdy;
    status[ST_TX_EMPTY] = tx_emt;
    host_rdata          = '0;
    if (stat_sel)      host_rdata = status;
    else if (data_sel) host_rdata = rx_hold;
  end
endmodule

// File: rtl/sio_chan_ctrl_chk.sv
module sio_chan_ctrl_chk
  import sio_pkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic [DATA_W-1:0] host_wdata,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic              tx_valid,
  input logic [DATA_W-1:0] tx_data,
  input logic              tx_ready,
  input logic              rx_int,
  input logic              tx_int,
  input logic              rx_evt,
  input logic              tx_evt
);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(OFS_CMD);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFS_DATA);

  AST_RX_HOLD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    rx_int |-> !rx_ready); // R4
  AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && rx_ready) |=> (rx_evt && rx_int)); // R4
  AST_RX_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == A_DATA && rx_int) |=> !rx_int); // R5
  AST_TX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_DATA && tx_int) |=> (tx_valid && !tx_int && tx_data == $past(host_wdata))); // R6
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R7
  AST_TX_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_CMD && host_wdata[3:2] == 2'b10) |=> !tx_int); // R3
  AST_TX_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    tx_int |-> !tx_valid); // R8
  AST_TX_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |-> (tx_int && !$past(tx_int))); // R8
endmodule

bind sio_chan_ctrl sio_chan_ctrl_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sio_chan_ctrl_tb.sv
module sio_chan_ctrl_tb;
  localparam int DW = 8;
  localparam int AW = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic          rst_n = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic          host_wr = 1'b0, host_rd = 1'b0;
  logic [DW-1:0] host_wdata = '0, host_rdata;
  logic          rx_valid = 1'b0, rx_ready;
  logic [DW-1:0] rx_data = '0;
  logic          tx_valid, tx_ready = 1'b0;
  logic [DW-1:0] tx_data;
  logic          rx_int, tx_int, rx_evt, tx_evt;

  sio_chan_ctrl #(.DATA_W(DW), .ADDR_W(AW)) u_dut (.*);

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_rx_en, m_full, m_tx_en, m_tx_rdy, m_tx_emt, m_done, m_rx_evt, m_tx_evt;
  logic [7:0] m_rx_byte;
  logic [7:0] m_q[$];
  bit c_cmd, c_load, c_take, c_cap, c_drain, c_acc, old_rdy;

  function automatic logic [7:0] m_status();
    return {4'h0, m_tx_emt, m_tx_rdy, m_full, m_full};
  endfunction

  always begin
    @(posedge clk);
    if (!rst_n) begin
      m_rx_en = 0; m_full = 0; m_tx_en = 0; m_tx_rdy = 0; m_tx_emt = 0;
      m_done = 0; m_rx_evt = 0; m_tx_evt = 0; m_rx_byte = 0; m_q.delete();
    end else begin
      c_cmd   = host_wr && host_addr == 3'd5;
      c_load  = host_wr && host_addr == 3'd7;
      c_take  = host_rd && host_addr == 3'd7;
      c_cap   = rx_valid && m_rx_en && !m_full;
      c_drain = m_q.size() > 0 && tx_ready;
      c_acc   = c_load && m_tx_rdy;
      old_rdy = m_tx_rdy;
      if (c_cap) begin m_full = 1; m_rx_byte = rx_data; end
      else if (c_take) m_full = 0;
      m_rx_evt = c_cap;
      if (c_cmd && host_wdata[1:0] == 2'b01) m_rx_en = 1;
      if (c_cmd && host_wdata[1:0] == 2'b10) m_rx_en = 0;
      if (c_cmd && host_wdata[3:2] == 2'b10) begin
        m_tx_en = 0; m_tx_rdy = 0; m_tx_emt = 0;
      end else if (c_cmd && host_wdata[3:2] == 2'b01) begin
        m_tx_en = 1;
        if (m_q.size() == 0) begin m_tx_rdy = 1; m_tx_emt = 1; end
      end else if (c_acc) begin
        m_tx_rdy = 0; m_tx_emt = 0;
      end else if (m_done && m_tx_en) begin
        m_tx_rdy = 1; m_tx_emt = 1;
      end
      if (c_drain) void'(m_q.pop_front());
      if (c_acc) m_q.push_back(host_wdata);
      m_done   = c_drain;
      m_tx_evt = m_tx_rdy && !old_rdy;
    end
    #3;
    if (rst_n) begin
      chk("R4", "rx_ready", rx_ready, m_rx_en && !m_full);
      chk("R4", "rx_evt", rx_evt, m_rx_evt);
      chk("R5", "rx_int", rx_int, m_full);
      chk("R6", "tx_int", tx_int, m_tx_rdy);
      chk("R7", "tx_valid", tx_valid, m_q.size() > 0);
      if (m_q.size() > 0) chk("R7", "tx_data", tx_data, m_q[0]);
      chk("R8", "tx_evt", tx_evt, m_tx_evt);
      if (host_rd && host_addr == 3'd3)      chk("R9", "rdata status", host_rdata, m_status());
      else if (host_rd && host_addr == 3'd7) chk("R9", "rdata byte", host_rdata, m_rx_byte);
      else                                   chk("R9", "rdata idle", host_rdata, 0);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    #2 d = host_rdata;
    @(negedge clk); host_rd = 1'b0;
  endtask

  task automatic line_push(input logic [7:0] d);
    @(negedge clk); rx_valid = 1'b1; rx_data = d;
    @(negedge clk); rx_valid = 1'b0;
  endtask

  logic [7:0] rd_v;

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "rx_ready", rx_ready, 0);
    chk("R1", "tx_valid", tx_valid, 0);
    chk("R1", "irq", {rx_int, tx_int, rx_evt, tx_evt}, 0);
    host_read(3'd3, rd_v); chk("R1", "status", rd_v, 8'h00);
    // R10 mode and clock-select writes
    host_write(3'd1, 8'hFF);
    host_write(3'd3, 8'hFF);
    host_read(3'd3, rd_v); chk("R10", "status after mode/csel", rd_v, 8'h00);
    chk("R10", "rx_ready after mode/csel", rx_ready, 0);
    // R2 receiver commands
    host_write(3'd5, 8'h01); chk("R2", "rx on", rx_ready, 1);
    host_write(3'd5, 8'h03); chk("R2", "rx field 11", rx_ready, 1);
    host_write(3'd5, 8'h00); chk("R2", "rx field 00", rx_ready, 1);
    // R4 capture and hold-off
    line_push(8'hA5);
    chk("R4", "full after capture", rx_int, 1);
    chk("R4", "hold-off", rx_ready, 0);
    host_read(3'd3, rd_v); chk("R9", "status rx full", rd_v, 8'h03);
    line_push(8'h3C);
    host_read(3'd7, rd_v); chk("R5", "byte kept", rd_v, 8'hA5);
    chk("R5", "rx_int cleared", rx_int, 0);
    line_push(8'h3C);
    host_read(3'd7, rd_v); chk("R4", "second byte", rd_v, 8'h3C);
    host_write(3'd5, 8'h02); chk("R2", "rx off", rx_ready, 0);
    line_push(8'h77); chk("R2", "disabled rx ignores", rx_int, 0);
    // R3 transmitter enable
    host_write(3'd5, 8'h04);
    host_read(3'd3, rd_v); chk("R3", "tx on status", rd_v, 8'h0C);
    host_write(3'd5, 8'h0C);
    host_read(3'd3, rd_v); chk("R3", "tx field 11", rd_v, 8'h0C);
    // R6 load with stalled line
    tx_ready = 1'b0;
    host_write(3'd7, 8'h5A);
    chk("R6", "tx_valid", tx_valid, 1);
    chk("R6", "tx_data", tx_data, 8'h5A);
    host_read(3'd3, rd_v); chk("R6", "status after load", rd_v, 8'h00);
    host_write(3'd7, 8'h99);
    chk("R10", "load while busy ignored", tx_data, 8'h5A);
    repeat (2) @(negedge clk);
    chk("R7", "held data", tx_data, 8'h5A);
    // R8 drain and flag return
    tx_ready = 1'b1;
    @(negedge clk);
    chk("R8", "drained", tx_valid, 0);
    chk("R8", "one cycle gap", tx_int, 0);
    @(negedge clk);
    chk("R8", "tx ready back", tx_int, 1);
    // R3 disable while a byte waits
    tx_ready = 1'b0;
    host_write(3'd7, 8'h11);
    host_write(3'd5, 8'h08);
    host_read(3'd3, rd_v); chk("R3", "tx off status", rd_v, 8'h00);
    chk("R7", "byte still offered", tx_valid, 1);
    tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", "disabled stays clear", tx_int, 0);
    chk("R8", "drained off", tx_valid, 0);
    // R3 enable while a byte waits
    host_write(3'd5, 8'h04);
    tx_ready = 1'b0;
    host_write(3'd7, 8'h22);
    host_write(3'd5, 8'h04);
    host_read(3'd3, rd_v); chk("R3", "enable while pending", rd_v, 8'h00);
    tx_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8", "ready after pending drain", tx_int, 1);
    // random phase, compared against the model each cycle
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      host_wr = 1'b0; host_rd = 1'b0;
      rx_valid = ($urandom % 3) == 0;
      rx_data  = 8'($urandom);
      tx_ready = ($urandom % 4) != 0;
      case ($urandom % 10)
        4: begin host_rd = 1'b1; host_addr = 3'd3; end
        5: begin host_rd = 1'b1; host_addr = 3'd7; end
        6: begin host_wr = 1'b1; host_addr = 3'd5; host_wdata = 8'($urandom); end
        7: begin host_wr = 1'b1; host_addr = 3'd7; host_wdata = 8'($urandom); end
        8: begin host_wr = 1'b1; host_addr = 3'(($urandom % 2) ? 1 : 3); host_wdata = 8'($urandom); end
        default: ;
      endcase
    end
    @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0; rx_valid = 1'b0;
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule